// File: doc/BRIEF.md
# Host Bus Mode and Shutdown Controller

This block holds the operating mode of a host bus interface in a 3-bit mode field. It also runs the orderly shutdown that happens when software writes the mode back to zero. A write of zero does not simply drop the interface. The block first looks at what the bus is doing at that moment. If the interface owns the bus as master, it ends the burst with a master termination. If it is the selected target of a memory access, it ends that access with a disconnect that tells the initiator to retry. If it is in the middle of a configuration access, it lets that access finish untouched.

After any of these, the block waits for the bus to go idle. It then drops the host-active flag and enters a low-power soft-reset state. In that state the data paths are held clear and every memory or configuration access aimed at the interface is answered with retry. A new nonzero mode write brings the interface back.

The transaction status arrives as plain level signals from the bus engine: master active, target selected, transaction kind and bus idle. The block returns plain strobes and levels. No data flows through it, so it has no valid/ready stream; every pin is a plain control or status signal, sampled on the rising clock edge.

Top module: `hostif_mode_ctrl`

## Requirements
- R1: After reset, cur_mode is 000, host_active is 0, path_clr is 1, low_power is 1, and mst_term and tgt_retry are 0 while no target access is presented.
- R2: Mode codes are 000 shutdown, 001 PCI, 010 universal bus, 011 enhanced universal bus, 100 GPIO and 101 self-configuration. A write of any nonzero valid code (001 to 101) takes effect at the write's clock edge: cur_mode shows the code and, coming from soft-reset, host_active is 1 from that edge on.
- R3: A write of a reserved code (110 or 111) is ignored, and cur_mode keeps its previous value.
- R4: A write of 000 while mst_active is 1 raises mst_term for exactly one cycle after the write edge, and raises no tgt_retry.
- R5: A write of 000 while tgt_sel is 1 with txn_kind memory (01) raises tgt_retry for exactly one cycle after the write edge, and raises no mst_term.
- R6: After a shutdown that had to end or finish a transaction, host_active stays 1 until bus_idle is sampled high at a clock edge, and is 0 from that edge on.
- R7: A write of 000 while neither mst_active nor tgt_sel is high clears host_active and sets cur_mode to 000 at the write edge, with no strobe.
- R8: While in soft-reset, path_clr is 1, and tgt_retry follows tgt_sel combinationally whenever txn_kind is memory (01) or configuration (10). With txn_kind none (00) or I/O (11), tgt_retry stays 0.
- R9: A write of 000 while tgt_sel is 1 with txn_kind configuration (10) raises neither tgt_retry nor mst_term, and the block waits for bus_idle as in R6.
- R10: low_power is 1 exactly when the block is in soft-reset or cur_mode is GPIO (100).
- R11: A valid nonzero write that arrives while a shutdown is waiting for bus idle is held, without changing cur_mode. It is applied one edge after soft-reset is reached, and host_active returns to 1 with the held code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code being written |
| mst_active | input | 1 | Interface owns the bus as master in a transaction |
| tgt_sel | input | 1 | Interface is the selected target of the current access |
| txn_kind | input | 2 | Current access kind: 00 none, 01 memory, 10 configuration, 11 I/O |
| bus_idle | input | 1 | Bus is in the idle state |
| mst_term | output | 1 | One-cycle master-initiated termination strobe |
| tgt_retry | output | 1 | Target disconnect / retry response |
| host_active | output | 1 | Host-active status flag |
| cur_mode | output | 3 | Current mode code |
| low_power | output | 1 | Interface is in a low-power state |
| path_clr | output | 1 | Data paths held clear |

## Verification
The assertions assume a well-behaved bus engine. mst_active and tgt_sel are never high together. A target access is only ever of memory, configuration or no kind, because I/O appears only when the interface is initiating. bus_idle stays low while a transaction the interface takes part in is still running. The directed scenarios keep to these rules. Every termination case holds bus_idle low until the transaction status has been withdrawn, and each scenario drops its role signals before letting the bus go idle.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  localparam int MODE_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SHUT    = 3'd0,
    MODE_PCI     = 3'd1,
    MODE_UB      = 3'd2,
    MODE_EUB     = 3'd3,
    MODE_GPIO    = 3'd4,
    MODE_SELFCFG = 3'd5,
    MODE_RSV6    = 3'd6,
    MODE_RSV7    = 3'd7
  } mode_e;

  typedef enum logic [KIND_W-1:0] {
    TK_NONE = 2'd0,
    TK_MEM  = 2'd1,
    TK_CFG  = 2'd2,
    TK_IO   = 2'd3
  } txn_kind_e;

  typedef enum logic [1:0] {
    CS_OFF  = 2'd0,
    CS_ON   = 2'd1,
    CS_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/hmc_mode_decode.sv
module hmc_mode_decode
  import hmc_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output logic              code_ok,
  output logic              code_shut
);
  mode_e m;
  always_comb begin
    m = mode_e'(code);
    code_ok   = 1'b1;
    code_shut = 1'b0;
    case (m)
      MODE_SHUT:                    code_shut = 1'b1;
      MODE_RSV6, MODE_RSV7:         code_ok   = 1'b0;
      default:                      code_ok   = 1'b1;
    endcase
  end
endmodule

// File: rtl/hmc_quiesce_fsm.sv
module hmc_quiesce_fsm
  import hmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              wr_ok,
  input  logic              wr_shut,
  input  logic              mst_active,
  input  logic              tgt_sel,
  input  logic [KIND_W-1:0] txn_kind,
  input  logic              bus_idle,
  output logic [MODE_W-1:0] mode_o,
  output logic              active_o,
  output logic              mterm_o,
  output logic              disc_o,
  output logic              in_off_o
);
  ctl_state_e        st;
  mode_e             mode_q;
  mode_e             pend_m;
  logic              pend_v;
  logic              act_q;
  logic              mterm_q;
  logic              disc_q;
  logic              tgt_mem;
  logic              tgt_cfg;
  logic              go_on;

  assign tgt_mem = tgt_sel && (txn_kind_e'(txn_kind) == TK_MEM);
  assign tgt_cfg = tgt_sel && (txn_kind_e'(txn_kind) == TK_CFG);
  assign go_on   = wr && wr_ok && !wr_shut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CS_OFF;
      mode_q  <= MODE_SHUT;
      pend_m  <= MODE_SHUT;
      pend_v  <= 1'b0;
      act_q   <= 1'b0;
      mterm_q <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      mterm_q <= 1'b0;
      disc_q  <= 1'b0;
      case (st)
        CS_OFF: begin
          if (wr && wr_ok && wr_shut) begin
            pend_v <= 1'b0;
          end else if (go_on) begin
            mode_q <= mode_e'(wdata);
            act_q  <= 1'b1;
            pend_v <= 1'b0;
            st     <= CS_ON;
          end else if (pend_v) begin
            mode_q <= pend_m;
            act_q  <= 1'b1;
            pend_v <= 1'b0;
            st     <= CS_ON;
          end
        end
        CS_ON: begin
          if (wr && wr_ok) begin
            if (wr_shut) begin
              mode_q <= MODE_SHUT;
              if (mst_active) begin
                mterm_q <= 1'b1;
                st      <= CS_WAIT;
              end else if (tgt_mem) begin
                disc_q <= 1'b1;
                st     <= CS_WAIT;
              end else if (tgt_cfg) begin
                st <= CS_WAIT;
              end else begin
                act_q <= 1'b0;
                st    <= CS_OFF;
              end
            end else begin
              mode_q <= mode_e'(wdata);
            end
          end
        end
        CS_WAIT: begin
          if (go_on) begin
            pend_v <= 1'b1;
            pend_m <= mode_e'(wdata);
          end else if (wr && wr_ok && wr_shut) begin
            pend_v <= 1'b0;
          end
          if (bus_idle) begin
            act_q <= 1'b0;
            st    <= CS_OFF;
          end
        end
        default: st <= CS_OFF;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign active_o = act_q;
  assign mterm_o  = mterm_q;
  assign disc_o   = disc_q;
  assign in_off_o = (st == CS_OFF);

  // R2
  activate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_OFF && go_on) |=> (act_q && mode_q == mode_e'($past(wdata))));

  // R3
  rsv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_ON && wr && !wr_ok) |=> $stable(mode_q));

  // R4
  mterm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mterm_q |=> !mterm_q);

  // R5
  disc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_q |=> !disc_q);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_WAIT && !bus_idle) |=> act_q);

  // R7
  quick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_ON && wr && wr_shut && !mst_active && !tgt_sel) |=> (!act_q && !mterm_q && !disc_q));

  // R9
  cfg_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_ON && wr && wr_shut && tgt_cfg && !mst_active) |=> (!disc_q && !mterm_q && act_q));

  // R11
  pend_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_OFF && pend_v && !wr) |=> (act_q && mode_q == $past(pend_m)));
endmodule

// File: rtl/hmc_resp_gen.sv
module hmc_resp_gen
  import hmc_pkg::*;
(
  input  logic              in_off,
  input  logic              disc,
  input  logic              tgt_sel,
  input  logic [KIND_W-1:0] txn_kind,
  input  logic [MODE_W-1:0] mode,
  output logic              tgt_retry,
  output logic              path_clr,
  output logic              low_power
);
  logic kind_retry;
  always_comb begin
    case (txn_kind_e'(txn_kind))
      TK_MEM, TK_CFG: kind_retry = 1'b1;
      default:        kind_retry = 1'b0;
    endcase
  end

  assign tgt_retry = disc | (in_off & tgt_sel & kind_retry);
  assign path_clr  = in_off;
  assign low_power = in_off | (mode_e'(mode) == MODE_GPIO);
endmodule

// File: rtl/hostif_mode_ctrl.sv
module hostif_mode_ctrl
  import hmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              mst_active,
  input  logic              tgt_sel,
  input  logic [KIND_W-1:0] txn_kind,
  input  logic              bus_idle,
  output logic              mst_term,
  output logic              tgt_retry,
  output logic              host_active,
  output logic [MODE_W-1:0] cur_mode,
  output logic              low_power,
  output logic              path_clr
);
  logic wr_ok;
  logic wr_shut;
  logic in_off;
  logic disc;

  hmc_mode_decode u_dec (
    .code      (mode_wdata),
    .code_ok   (wr_ok),
    .code_shut (wr_shut)
  );

  hmc_quiesce_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (mode_wr),
    .wdata      (mode_wdata),
    .wr_ok      (wr_ok),
    .wr_shut    (wr_shut),
    .mst_active (mst_active),
    .tgt_sel    (tgt_sel),
    .txn_kind   (txn_kind),
    .bus_idle   (bus_idle),
    .mode_o     (cur_mode),
    .active_o   (host_active),
    .mterm_o    (mst_term),
    .disc_o     (disc),
    .in_off_o   (in_off)
  );

  hmc_resp_gen u_resp (
    .in_off    (in_off),
    .disc      (disc),
    .tgt_sel   (tgt_sel),
    .txn_kind  (txn_kind),
    .mode      (cur_mode),
    .tgt_retry (tgt_retry),
    .path_clr  (path_clr),
    .low_power (low_power)
  );

  // R8
  off_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_active && tgt_sel && (txn_kind == 2'd1 || txn_kind == 2'd2)) |-> (tgt_retry && path_clr));

  // R10
  low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power == (!host_active || cur_mode == 3'd4));

  // R4
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_term |-> !tgt_retry);
endmodule

// File: tb/hostif_mode_ctrl_tb.sv
module hostif_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_wdata = 3'd0;
  logic       mst_active = 1'b0;
  logic       tgt_sel = 1'b0;
  logic [1:0] txn_kind = 2'd0;
  logic       bus_idle = 1'b1;
  logic       mst_term, tgt_retry, host_active, low_power, path_clr;
  logic [2:0] cur_mode;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hostif_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mst_active(mst_active), .tgt_sel(tgt_sel), .txn_kind(txn_kind),
    .bus_idle(bus_idle), .mst_term(mst_term), .tgt_retry(tgt_retry),
    .host_active(host_active), .cur_mode(cur_mode), .low_power(low_power),
    .path_clr(path_clr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Starts at a negedge, ends at the next negedge with the write applied.
  task automatic wr_mode(input logic [2:0] m);
    mode_wr = 1'b1;
    mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "cur_mode", cur_mode, 0);
    chk("R1", "host_active", host_active, 0);
    chk("R1", "path_clr", path_clr, 1);
    chk("R1", "low_power", low_power, 1);
    chk("R1", "mst_term", mst_term, 0);
    chk("R1", "tgt_retry", tgt_retry, 0);
  endtask

  task automatic t_enable;
    wr_mode(3'd1);
    chk("R2", "pci cur_mode", cur_mode, 1);
    chk("R2", "pci host_active", host_active, 1);
    chk("R10", "pci low_power", low_power, 0);
    chk("R8", "pci path_clr", path_clr, 0);
    wr_mode(3'd4);
    chk("R2", "gpio cur_mode", cur_mode, 4);
    chk("R10", "gpio low_power", low_power, 1);
    wr_mode(3'd2);
    chk("R2", "ub cur_mode", cur_mode, 2);
    chk("R10", "ub low_power", low_power, 0);
    wr_mode(3'd3);
    chk("R2", "eub cur_mode", cur_mode, 3);
    wr_mode(3'd5);
    chk("R2", "selfcfg cur_mode", cur_mode, 5);
  endtask

  task automatic t_reserved;
    wr_mode(3'd6);
    chk("R3", "code 6 ignored", cur_mode, 5);
    wr_mode(3'd7);
    chk("R3", "code 7 ignored", cur_mode, 5);
    chk("R3", "still active", host_active, 1);
  endtask

  task automatic t_immediate;
    wr_mode(3'd0);
    chk("R7", "host_active", host_active, 0);
    chk("R7", "cur_mode", cur_mode, 0);
    chk("R7", "mst_term", mst_term, 0);
    chk("R7", "tgt_retry", tgt_retry, 0);
    wr_mode(3'd6);
    chk("R3", "reserved in soft-reset", host_active, 0);
  endtask

  task automatic t_master;
    wr_mode(3'd1);
    bus_idle = 1'b0;
    mst_active = 1'b1;
    wr_mode(3'd0);
    chk("R4", "mst_term raised", mst_term, 1);
    chk("R4", "no retry", tgt_retry, 0);
    chk("R6", "active during wait", host_active, 1);
    mst_active = 1'b0;
    @(negedge clk);
    chk("R4", "mst_term one cycle", mst_term, 0);
    chk("R6", "active before idle", host_active, 1);
    @(negedge clk);
    chk("R6", "active still", host_active, 1);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R6", "dropped after idle", host_active, 0);
    chk("R8", "path_clr", path_clr, 1);
  endtask

  task automatic t_target_mem;
    wr_mode(3'd1);
    bus_idle = 1'b0;
    tgt_sel = 1'b1;
    txn_kind = 2'd1;
    wr_mode(3'd0);
    chk("R5", "retry raised", tgt_retry, 1);
    chk("R5", "no mst_term", mst_term, 0);
    tgt_sel = 1'b0;
    txn_kind = 2'd0;
    @(negedge clk);
    chk("R5", "retry one cycle", tgt_retry, 0);
    chk("R6", "active before idle", host_active, 1);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R6", "dropped after idle", host_active, 0);
  endtask

  task automatic t_soft_retry;
    tgt_sel = 1'b1;
    txn_kind = 2'd1;
    #1;
    chk("R8", "mem retried", tgt_retry, 1);
    txn_kind = 2'd2;
    #1;
    chk("R8", "cfg retried", tgt_retry, 1);
    txn_kind = 2'd3;
    #1;
    chk("R8", "io not retried", tgt_retry, 0);
    txn_kind = 2'd1;
    tgt_sel = 1'b0;
    #1;
    chk("R8", "unselected not retried", tgt_retry, 0);
    txn_kind = 2'd0;
    @(negedge clk);
  endtask

  task automatic t_cfg;
    wr_mode(3'd1);
    bus_idle = 1'b0;
    tgt_sel = 1'b1;
    txn_kind = 2'd2;
    wr_mode(3'd0);
    chk("R9", "no retry", tgt_retry, 0);
    chk("R9", "no mst_term", mst_term, 0);
    chk("R9", "active", host_active, 1);
    @(negedge clk);
    chk("R9", "still no retry", tgt_retry, 0);
    chk("R9", "still active", host_active, 1);
    tgt_sel = 1'b0;
    txn_kind = 2'd0;
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R9", "dropped after idle", host_active, 0);
  endtask

  task automatic t_pending;
    wr_mode(3'd1);
    bus_idle = 1'b0;
    mst_active = 1'b1;
    wr_mode(3'd0);
    mst_active = 1'b0;
    wr_mode(3'd4);
    chk("R11", "held cur_mode", cur_mode, 0);
    chk("R11", "still waiting", host_active, 1);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R11", "soft-reset reached", host_active, 0);
    @(negedge clk);
    chk("R11", "applied active", host_active, 1);
    chk("R11", "applied mode", cur_mode, 4);
    chk("R10", "gpio low_power", low_power, 1);
    wr_mode(3'd0);
    chk("R7", "back off", host_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_reserved();
    t_immediate();
    t_master();
    t_target_mem();
    t_soft_retry();
    t_cfg();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule